// File: doc/BRIEF.md
# Sixteen-Bit Register Machine Core

This block is a small 16-bit processor core. Code and data share one internal byte memory. The core has four general registers (q0..q3), an instruction pointer, a stack pointer and a flags register. Each instruction begins with a 16-bit code, stored low byte first. The core reads that code at the instruction pointer and moves the pointer forward by 2. It then decodes the code into one operation tied to a fixed set of registers. Every register combination has its own code: no fields in the code select a register.

The core runs each instruction in two phases of one clock cycle each. The first phase fetches the code. The second phase reads any operand and performs the operation. The operations are no-op, halt, immediate word and byte moves, word and byte moves between registers, loads and stores with a direct or an indirect address, and word push and pop.

A preload port writes bytes into the memory while the `run` input is low. A debug read port returns any byte at any time. The registers and the pointers are brought out as outputs, so a test or a debugger can observe the machine state after a program halts.

Top module: `rm16_core`

## Requirements
- R1: A synchronous reset clears q0..q3, the instruction pointer, the stack pointer, the flags, `halted` and `illegal`. After reset the first fetch is at address 0.
- R2: Each instruction code is a 16-bit word read at the instruction pointer, low byte at the lower address. The pointer then advances by 2. No-op is code 0 and changes nothing else. Halt is code 1: it sets `halted`, and from then on the pointers and the registers never change until the next reset.
- R3: Codes 2..5 load a 16-bit immediate that follows the code into q0..q3, and advance the pointer by 2 more. Codes 6..9 take a one-byte immediate into the low byte of q0..q3, keep the upper byte, and advance the pointer by only 1. Later fetches may therefore be at odd addresses.
- R4: Codes 10..21 copy a whole register and codes 22..33 copy only the low byte, keeping the target's upper byte. Within each group, the target goes from q0 to q3 and, for each target, the source rises through the other three registers. The code is base + 3·target + (source > target ? source−1 : source).
- R5: Direct access carries a 16-bit address word after the code. The pointer advances by 2 past that word, and the address is taken modulo 1024. The groups are: load word 34..37, load byte 38..41, store word 42..45 and store byte 46..49, each in q0..q3 order. A word access puts the low byte at the address and the high byte at the address + 1, modulo 1024. A byte load keeps the upper byte of the register, and a byte store writes the register's low byte.
- R6: Indirect access takes its address from q0, modulo 1024, and the data register is q1..q3 only. The groups are: load word 50..52, load byte 53..55, store word 56..58 and store byte 59..61.
- R7: Push, codes 62..65 for q0..q3, first lowers the stack pointer by 2 and then writes the word there. Pop, codes 66..69 for q0..q3, reads the word at the stack pointer and then raises the pointer by 2. The stack pointer wraps modulo 1024.
- R8: Code and data share the memory. A store over a code that has not yet been fetched changes the instruction that executes there.
- R9: No implemented instruction changes the flags output, which stays 0.
- R10: Any code of 70 or above sets `illegal` and `halted`, and the instruction has no other effect.
- R11: While `run` is low the core holds all its state. `pl_we` writes `pl_data` at `pl_addr` on the clock edge. `dbg_data` always shows the byte at `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Core advances only while high |
| pl_we | input | 1 | Preload byte write enable |
| pl_addr | input | 10 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| dbg_addr | input | 10 | Debug read address |
| dbg_data | output | 8 | Byte at debug address |
| q0 | output | 16 | General register 0 |
| q1 | output | 16 | General register 1 |
| q2 | output | 16 | General register 2 |
| q3 | output | 16 | General register 3 |
| ip | output | 10 | Instruction pointer |
| sp | output | 10 | Stack pointer |
| flags | output | 16 | Flags register |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | An unassigned code was executed |

## Verification
The assertions assume that reset is held for at least one edge at the start. They also assume that the preload port is used only while `run` is low, because a preload write takes priority over a store by the core in the same cycle. The stimulus keeps to these rules. It resets before each program, loads the program with `run` low, raises `run` until `halted` rises, and only then reads registers and memory. Each program ends in a halt code, so the core never fetches from bytes that were never written.

// File: rtl/rm16_pkg.sv
package rm16_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {S_FETCH, S_EXEC} phase_e;

  typedef enum logic [4:0] {
    K_NOP, K_HALT, K_MOVIW, K_MOVIB, K_MOVW, K_MOVB,
    K_LDWD, K_LDBD, K_STWD, K_STBD,
    K_LDWI, K_LDBI, K_STWI, K_STBI,
    K_PUSH, K_POP, K_ILL
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] dst;
    logic [1:0] src;
  } op_t;

  // code group bases, in the order the codes are handed out
  localparam int B_MOVIW = 2;
  localparam int B_MOVIB = 6;
  localparam int B_MOVW  = 10;
  localparam int B_MOVB  = 22;
  localparam int B_DIR   = 34;
  localparam int B_IND   = 50;
  localparam int B_PUSH  = 62;
  localparam int B_POP   = 66;
  localparam int B_END   = 70;

  // target/source for the n-th ordered pair of distinct registers
  function automatic op_t pair_of(input kind_e k, input word_t idx);
    op_t  o;
    word_t t;
    word_t r;
    t = idx / 16'd3;
    r = idx % 16'd3;
    o.kind = k;
    o.dst  = t[1:0];
    o.src  = (r[1:0] >= t[1:0]) ? r[1:0] + 2'd1 : r[1:0];
    return o;
  endfunction

  function automatic op_t decode_op(input word_t code);
    op_t   o;
    word_t off;
    word_t grp;
    word_t rem;
    o.kind = K_ILL;
    o.dst  = 2'd0;
    o.src  = 2'd0;
    if (code == 16'd0) begin
      o.kind = K_NOP;
    end else if (code == 16'd1) begin
      o.kind = K_HALT;
    end else if (code < word_t'(B_MOVIB)) begin
      off = code - word_t'(B_MOVIW);
      o.kind = K_MOVIW;
      o.dst  = off[1:0];
    end else if (code < word_t'(B_MOVW)) begin
      off = code - word_t'(B_MOVIB);
      o.kind = K_MOVIB;
      o.dst  = off[1:0];
    end else if (code < word_t'(B_MOVB)) begin
      o = pair_of(K_MOVW, code - word_t'(B_MOVW));
    end else if (code < word_t'(B_DIR)) begin
      o = pair_of(K_MOVB, code - word_t'(B_MOVB));
    end else if (code < word_t'(B_IND)) begin
      off = code - word_t'(B_DIR);
      grp = off >> 2;
      o.dst = off[1:0];
      case (grp[1:0])
        2'd0:    o.kind = K_LDWD;
        2'd1:    o.kind = K_LDBD;
        2'd2:    o.kind = K_STWD;
        default: o.kind = K_STBD;
      endcase
    end else if (code < word_t'(B_PUSH)) begin
      off = code - word_t'(B_IND);
      grp = off / 16'd3;
      rem = off % 16'd3;
      o.dst = rem[1:0] + 2'd1;
      case (grp[1:0])
        2'd0:    o.kind = K_LDWI;
        2'd1:    o.kind = K_LDBI;
        2'd2:    o.kind = K_STWI;
        default: o.kind = K_STBI;
      endcase
    end else if (code < word_t'(B_POP)) begin
      off = code - word_t'(B_PUSH);
      o.kind = K_PUSH;
      o.dst  = off[1:0];
    end else if (code < word_t'(B_END)) begin
      off = code - word_t'(B_POP);
      o.kind = K_POP;
      o.dst  = off[1:0];
    end
    return o;
  endfunction

  // extra pointer advance in the execute phase, past inline operands
  function automatic logic [1:0] operand_len(input kind_e k);
    case (k)
      K_MOVIW, K_LDWD, K_LDBD, K_STWD, K_STBD: return 2'd2;
      K_MOVIB:                                 return 2'd1;
      default:                                 return 2'd0;
    endcase
  endfunction

  function automatic word_t merge_low(input word_t old_v, input word_t new_v,
                                      input logic byte_only);
    return byte_only ? {old_v[WORD_W-1:BYTE_W], new_v[BYTE_W-1:0]} : new_v;
  endfunction

endpackage

// File: rtl/rm16_mem.sv
module rm16_mem #(
  parameter int ADDR_W = 10,
  parameter int NRD    = 5
) (
  input  logic                         clk,
  input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
  output logic [NRD-1:0][7:0]          rd_data,
  input  logic                         wr_lo,
  input  logic                         wr_hi,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [15:0]                  wr_data,
  input  logic                         pl_we,
  input  logic [ADDR_W-1:0]            pl_addr,
  input  logic [7:0]                   pl_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [7:0] cells [DEPTH];
  logic [ADDR_W-1:0] wr_addr_hi;

  assign wr_addr_hi = wr_addr + ONE;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = cells[rd_addr[p]];
  end

  always_ff @(posedge clk) begin
    if (pl_we) begin
      cells[pl_addr] <= pl_data;
    end else begin
      if (wr_lo) cells[wr_addr]    <= wr_data[7:0];
      if (wr_hi) cells[wr_addr_hi] <= wr_data[15:8];
    end
  end
endmodule

// File: rtl/rm16_decode.sv
module rm16_decode
  import rm16_pkg::*;
(
  input  word_t code,
  output op_t   op
);
  always_comb op = decode_op(code);
endmodule

// File: rtl/rm16_regfile.sv
module rm16_regfile
  import rm16_pkg::*;
#(
  parameter int NREG = 4,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  byte_only,
  input  logic [SEL_W-1:0]      wsel,
  input  word_t                 wdata,
  output logic [NREG-1:0][15:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (we && wsel == SEL_W'(i))
        regs[i] <= merge_low(regs[i], wdata, byte_only);
    end
  end
endmodule

// File: rtl/rm16_core.sv
module rm16_core
  import rm16_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [7:0]        dbg_data,
  output logic [15:0]       q0,
  output logic [15:0]       q1,
  output logic [15:0]       q2,
  output logic [15:0]       q3,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] sp,
  output logic [FLAG_W-1:0] flags,
  output logic              halted,
  output logic              illegal
);
  localparam int NREG = 4;
  localparam int NRD  = 5;
  localparam logic [ADDR_W-1:0] ONE  = 1;
  localparam logic [ADDR_W-1:0] STEP = 2;

  phase_e             phase_q;
  logic [ADDR_W-1:0]  ip_q, sp_q;
  word_t              ir_q;
  logic [FLAG_W-1:0]  flags_q;
  logic               halted_q, illegal_q;
  logic [NREG-1:0][15:0] regs;

  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0][7:0]        rd_data;
  op_t                op;
  word_t              opw, dw;
  logic [ADDR_W-1:0]  ea, sp_dn, sp_up, ip_exec;

  // named events, also watched by the checker
  logic fetch_fire, exec_fire, byteimm_fire, push_fire, pop_fire;

  logic        rf_we, rf_byte;
  logic [1:0]  rf_sel;
  word_t       rf_data;
  logic        mw_lo, mw_hi;

  assign fetch_fire   = run && !halted_q && phase_q == S_FETCH;
  assign exec_fire    = run && !halted_q && phase_q == S_EXEC;
  assign byteimm_fire = exec_fire && op.kind == K_MOVIB;
  assign push_fire    = exec_fire && op.kind == K_PUSH;
  assign pop_fire     = exec_fire && op.kind == K_POP;

  rm16_decode u_dec (.code(ir_q), .op(op));

  assign opw   = {rd_data[1], rd_data[0]};
  assign dw    = {rd_data[3], rd_data[2]};
  assign sp_dn = sp_q - STEP;
  assign sp_up = sp_q + STEP;
  assign ip_exec = ip_q + {{(ADDR_W-2){1'b0}}, operand_len(op.kind)};

  always_comb begin
    case (op.kind)
      K_LDWD, K_LDBD, K_STWD, K_STBD: ea = opw[ADDR_W-1:0];
      K_LDWI, K_LDBI, K_STWI, K_STBI: ea = regs[0][ADDR_W-1:0];
      K_PUSH:                         ea = sp_dn;
      default:                        ea = sp_q;
    endcase
  end

  always_comb begin
    rd_addr[0] = ip_q;
    rd_addr[1] = ip_q + ONE;
    rd_addr[2] = ea;
    rd_addr[3] = ea + ONE;
    rd_addr[4] = dbg_addr;
  end

  rm16_mem #(.ADDR_W(ADDR_W), .NRD(NRD)) u_mem (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_lo   (mw_lo),
    .wr_hi   (mw_hi),
    .wr_addr (ea),
    .wr_data (regs[op.dst]),
    .pl_we   (pl_we),
    .pl_addr (pl_addr),
    .pl_data (pl_data)
  );

  always_comb begin
    rf_we   = 1'b0;
    rf_byte = 1'b0;
    rf_sel  = op.dst;
    rf_data = opw;
    mw_lo   = 1'b0;
    mw_hi   = 1'b0;
    if (exec_fire) begin
      case (op.kind)
        K_MOVIW: rf_we = 1'b1;
        K_MOVIB: begin
          rf_we = 1'b1; rf_byte = 1'b1; rf_data = {8'h00, rd_data[0]};
        end
        K_MOVW: begin
          rf_we = 1'b1; rf_data = regs[op.src];
        end
        K_MOVB: begin
          rf_we = 1'b1; rf_byte = 1'b1; rf_data = regs[op.src];
        end
        K_LDWD, K_LDWI, K_POP: begin
          rf_we = 1'b1; rf_data = dw;
        end
        K_LDBD, K_LDBI: begin
          rf_we = 1'b1; rf_byte = 1'b1; rf_data = {8'h00, rd_data[2]};
        end
        K_STWD, K_STWI, K_PUSH: begin
          mw_lo = 1'b1; mw_hi = 1'b1;
        end
        K_STBD, K_STBI: mw_lo = 1'b1;
        default: ;
      endcase
    end
  end

  rm16_regfile #(.NREG(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .byte_only (rf_byte),
    .wsel      (rf_sel),
    .wdata     (rf_data),
    .regs      (regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= S_FETCH;
      ip_q      <= '0;
      sp_q      <= '0;
      ir_q      <= '0;
      flags_q   <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else if (fetch_fire) begin
      ir_q    <= opw;
      ip_q    <= ip_q + STEP;
      phase_q <= S_EXEC;
    end else if (exec_fire) begin
      ip_q    <= ip_exec;
      phase_q <= S_FETCH;
      if (push_fire) sp_q <= sp_dn;
      if (pop_fire)  sp_q <= sp_up;
      if (op.kind == K_HALT || op.kind == K_ILL) halted_q <= 1'b1;
      if (op.kind == K_ILL) illegal_q <= 1'b1;
    end
  end

  assign dbg_data = rd_data[4];
  assign q0 = regs[0];
  assign q1 = regs[1];
  assign q2 = regs[2];
  assign q3 = regs[3];
  assign ip = ip_q;
  assign sp = sp_q;
  assign flags   = flags_q;
  assign halted  = halted_q;
  assign illegal = illegal_q;
endmodule

// File: rtl/rm16_chk.sv
module rm16_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              fetch_fire,
  input logic              byteimm_fire,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              halted,
  input logic              illegal,
  input logic [ADDR_W-1:0] ip_q,
  input logic [ADDR_W-1:0] sp_q
);
  localparam logic [ADDR_W-1:0] ONE = 1;
  localparam logic [ADDR_W-1:0] TWO = 2;

  logic [ADDR_W-1:0] ip_p1, ip_p2, sp_m2, sp_p2;
  assign ip_p1 = ip_q + ONE;
  assign ip_p2 = ip_q + TWO;
  assign sp_m2 = sp_q - TWO;
  assign sp_p2 = sp_q + TWO;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ip_q == '0 && sp_q == '0 && !halted && !illegal));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> ip_q == $past(ip_p2));

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(ip_q) && $stable(sp_q)));

  // R3
  byte_imm_step_chk: assert property (@(posedge clk) disable iff (rst)
    byteimm_fire |=> ip_q == $past(ip_p1));

  // R7
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    push_fire |=> sp_q == $past(sp_m2));

  // R7
  pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
    pop_fire |=> sp_q == $past(sp_p2));

  // R10
  illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R11
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(ip_q) && $stable(sp_q)));
endmodule

bind rm16_core rm16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run          (run),
  .fetch_fire   (fetch_fire),
  .byteimm_fire (byteimm_fire),
  .push_fire    (push_fire),
  .pop_fire     (pop_fire),
  .halted       (halted_q),
  .illegal      (illegal_q),
  .ip_q         (ip_q),
  .sp_q         (sp_q)
);

// File: tb/rm16_core_tb.sv
`timescale 1ns/1ps
module rm16_core_tb;
  localparam int AW = 10;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [AW-1:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic [15:0] q0, q1, q2, q3, flags;
  logic [AW-1:0] ip, sp;
  logic halted, illegal;

  always #5 clk = ~clk;

  rm16_core u_dut (
    .clk(clk), .rst(rst), .run(run), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_data(pl_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .q0(q0), .q1(q1), .q2(q2), .q3(q3), .ip(ip), .sp(sp), .flags(flags),
    .halted(halted), .illegal(illegal)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int pcb   = 0;

  // code values restated from the requirements
  localparam logic [15:0] C_NOP = 0, C_HALT = 1, C_MOVIW = 2, C_MOVIB = 6;
  localparam logic [15:0] C_LDWD = 34, C_LDBD = 38, C_STWD = 42, C_STBD = 46;
  localparam logic [15:0] C_LDWI = 50, C_LDBI = 53, C_STWI = 56, C_STBI = 59;
  localparam logic [15:0] C_PUSH = 62, C_POP = 66;

  function automatic logic [15:0] pair_code(input int base, input int t, input int s);
    int slot;
    slot = (s > t) ? s - 1 : s;
    return 16'(base + 3 * t + slot);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pl_byte(input int a, input logic [7:0] d);
    pl_we = 1'b1;
    pl_addr = AW'(a);
    pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic emit_w(input logic [15:0] v);
    pl_byte(pcb, v[7:0]);
    pl_byte(pcb + 1, v[15:8]);
    pcb += 2;
  endtask

  task automatic emit_b(input logic [7:0] v);
    pl_byte(pcb, v);
    pcb += 1;
  endtask

  task automatic rd_mem(input int a, output logic [7:0] v);
    dbg_addr = AW'(a);
    #1;
    v = dbg_data;
  endtask

  task automatic run_prog(input string req);
    run = 1'b1;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    run = 1'b0;
    chk(req, "halted after program", 32'(halted), 1);
  endtask

  task automatic chk_regs(input string req, input logic [15:0] e0, input logic [15:0] e1,
                          input logic [15:0] e2, input logic [15:0] e3);
    chk(req, "q0", 32'(q0), 32'(e0));
    chk(req, "q1", 32'(q1), 32'(e1));
    chk(req, "q2", 32'(q2), 32'(e2));
    chk(req, "q3", 32'(q3), 32'(e3));
    chk("R9", "flags unchanged", 32'(flags), 0);
  endtask

  task automatic chk_mem(input string req, input int a, input logic [7:0] e);
    logic [7:0] v;
    rd_mem(a, v);
    chk(req, $sformatf("mem[%0h]", a), 32'(v), 32'(e));
  endtask

  task automatic clear_mem();
    @(negedge clk);
    for (int a = 0; a < (1 << AW); a++) pl_byte(a, 8'h00);
  endtask

  task automatic t_reset();
    do_reset();
    chk_regs("R1", 0, 0, 0, 0);
    chk("R1", "ip", 32'(ip), 0);
    chk("R1", "sp", 32'(sp), 0);
    chk("R1", "halted", 32'(halted), 0);
    chk("R1", "illegal", 32'(illegal), 0);
  endtask

  task automatic t_pause_preload();
    logic [7:0] v;
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'h4444); emit_w(C_HALT);
    pl_byte(16'h155, 8'h3c);
    rd_mem(16'h155, v);
    chk("R11", "debug read of preloaded byte", 32'(v), 32'h3c);
    repeat (20) @(negedge clk);
    chk("R11", "ip held while run low", 32'(ip), 0);
    chk("R11", "q0 held while run low", 32'(q0), 0);
    run_prog("R1");
    chk("R1", "first fetch at 0 -> q0", 32'(q0), 32'h4444);
    chk("R1", "ip after program", 32'(ip), 6);
  endtask

  task automatic t_noop_halt();
    do_reset();
    pcb = 0;
    emit_w(C_NOP); emit_w(C_NOP); emit_w(C_HALT);
    run_prog("R2");
    chk("R2", "ip past halt", 32'(ip), 6);
    chk_regs("R2", 0, 0, 0, 0);
    chk("R2", "sp after no-op", 32'(sp), 0);
    run = 1'b1;
    repeat (10) @(negedge clk);
    run = 1'b0;
    chk("R2", "ip frozen after halt", 32'(ip), 6);
    chk("R2", "halted stays", 32'(halted), 1);
  endtask

  task automatic t_immediates();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'hbeef);
    emit_w(C_MOVIB + 0); emit_b(8'h12);
    emit_w(C_MOVIW + 1); emit_w(16'h1234);
    emit_w(C_MOVIB + 3); emit_b(8'hab);
    emit_w(C_HALT);
    run_prog("R3");
    chk_regs("R3", 16'hbe12, 16'h1234, 16'h0000, 16'h00ab);
    chk("R3", "ip after odd-aligned program", 32'(ip), 16);
  endtask

  task automatic t_moves_mix();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'hbeef);
    emit_w(C_MOVIW + 1); emit_w(16'hfeed);
    emit_w(pair_code(22, 2, 1));
    emit_w(pair_code(10, 3, 0));
    emit_w(pair_code(10, 0, 2));
    emit_w(pair_code(22, 1, 3));
    emit_w(C_HALT);
    run_prog("R4");
    chk_regs("R4", 16'h00ed, 16'hfeef, 16'h00ed, 16'hbeef);
    chk("R4", "ip", 32'(ip), 18);
  endtask

  task automatic t_move_pairs();
    logic [15:0] v [4];
    logic [15:0] e [4];
    for (int i = 0; i < 4; i++) v[i] = 16'h1111 * 16'(i + 1);
    for (int byt = 0; byt < 2; byt++) begin
      for (int t = 0; t < 4; t++) begin
        for (int s = 0; s < 4; s++) begin
          if (s != t) begin
            do_reset();
            pcb = 0;
            for (int r = 0; r < 4; r++) begin
              emit_w(C_MOVIW + 16'(r)); emit_w(v[r]);
            end
            emit_w(pair_code(byt ? 22 : 10, t, s));
            emit_w(C_HALT);
            run_prog("R4");
            for (int r = 0; r < 4; r++) e[r] = v[r];
            e[t] = byt ? {v[t][15:8], v[s][7:0]} : v[s];
            chk_regs($sformatf("R4 %s t%0d s%0d", byt ? "byte" : "word", t, s),
                     e[0], e[1], e[2], e[3]);
          end
        end
      end
    end
  endtask

  task automatic t_direct();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 3); emit_w(16'h7700);
    emit_w(C_MOVIW + 2); emit_w(16'ha55a);
    emit_w(C_STWD + 2);  emit_w(16'h0200);
    emit_w(C_STBD + 2);  emit_w(16'h0300);
    emit_w(C_LDWD + 1);  emit_w(16'h0600);
    emit_w(C_LDBD + 3);  emit_w(16'h0300);
    emit_w(C_STWD + 2);  emit_w(16'h03ff);
    emit_w(C_HALT);
    run_prog("R5");
    chk_regs("R5", 16'h0000, 16'ha55a, 16'ha55a, 16'h775a);
    chk("R5", "ip", 32'(ip), 30);
    chk_mem("R5", 16'h200, 8'h5a);
    chk_mem("R5", 16'h201, 8'ha5);
    chk_mem("R5", 16'h300, 8'h5a);
    chk_mem("R5", 16'h301, 8'h00);
    chk_mem("R5", 16'h3ff, 8'h5a);
    chk_mem("R5", 16'h000, 8'ha5);
  endtask

  task automatic t_indirect();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'h0100);
    emit_w(C_MOVIW + 1); emit_w(16'h1357);
    emit_w(C_STWI + 0);
    emit_w(C_MOVIW + 2); emit_w(16'h00c3);
    emit_w(C_MOVIW + 0); emit_w(16'h0502);
    emit_w(C_STBI + 1);
    emit_w(C_MOVIW + 0); emit_w(16'h0100);
    emit_w(C_LDWI + 2);
    emit_w(C_MOVIW + 0); emit_w(16'h0102);
    emit_w(C_MOVIW + 2); emit_w(16'haa00);
    emit_w(C_LDBI + 1);
    emit_w(C_HALT);
    run_prog("R6");
    chk_regs("R6", 16'h0102, 16'h1357, 16'haac3, 16'h1357);
    chk("R6", "ip", 32'(ip), 38);
    chk_mem("R6", 16'h100, 8'h57);
    chk_mem("R6", 16'h101, 8'h13);
    chk_mem("R6", 16'h102, 8'hc3);
  endtask

  task automatic t_stack();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'hbeef);
    emit_w(C_MOVIW + 1); emit_w(16'hfeed);
    emit_w(C_PUSH + 0);
    emit_w(C_PUSH + 1);
    emit_w(C_HALT);
    run_prog("R7");
    chk("R7", "sp after two pushes wraps", 32'(sp), 32'h3fc);
    chk_mem("R7", 16'h3fc, 8'hed);
    chk_mem("R7", 16'h3fd, 8'hfe);
    chk_mem("R7", 16'h3fe, 8'hef);
    chk_mem("R7", 16'h3ff, 8'hbe);
    do_reset();
    pcb = 12;
    emit_w(C_POP + 2);
    emit_w(C_POP + 3);
    emit_w(C_HALT);
    run_prog("R7");
    chk_regs("R7", 16'hbeef, 16'hfeed, 16'hfeed, 16'hbeef);
    chk("R7", "sp after pops", 32'(sp), 0);
    chk("R7", "ip", 32'(ip), 18);
  endtask

  task automatic t_selfmod();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 1); emit_w(C_HALT);
    emit_w(C_STWD + 1);  emit_w(16'h000c);
    emit_w(C_NOP);
    emit_w(C_NOP);
    emit_w(C_MOVIW + 0); emit_w(16'h5555);
    emit_w(C_HALT);
    run_prog("R8");
    chk("R8", "patched code halts early: ip", 32'(ip), 14);
    chk("R8", "patched code: q0 untouched", 32'(q0), 0);
  endtask

  task automatic t_illegal();
    do_reset();
    pcb = 0;
    emit_w(C_MOVIW + 0); emit_w(16'h1111);
    emit_w(16'd70);
    emit_w(C_MOVIW + 1); emit_w(16'h2222);
    emit_w(C_HALT);
    run_prog("R10");
    chk("R10", "illegal flag for code 70", 32'(illegal), 1);
    chk("R10", "ip stops after bad code", 32'(ip), 6);
    chk_regs("R10", 16'h1111, 0, 0, 0);
    do_reset();
    chk("R10", "illegal cleared by reset", 32'(illegal), 0);
    pcb = 0;
    emit_w(16'hffff);
    run_prog("R10");
    chk("R10", "illegal flag for code ffff", 32'(illegal), 1);
    chk("R10", "ip after ffff", 32'(ip), 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL WATCHDOG: actual %0d cycles expected earlier completion", WD_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    clear_mem();
    t_pause_preload();
    t_noop_halt();
    t_immediates();
    t_moves_mix();
    t_move_pairs();
    t_direct();
    t_indirect();
    t_stack();
    t_selfmod();
    t_illegal();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule